// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block performs the processor-side work once an interrupt has been granted, and again when a handler returns. When the interrupt controller offers a request, the block checks the request level against the mask field of the status register. If the request passes, the block acknowledges it and captures the vector, the level and the current context. It then saves the program counter and the status register on a downward-growing stack over a 16-bit memory port. Next it fetches the handler address from the vector table and gives the processor a new program counter, status register and stack pointer in one load strobe. The new status register carries a raised mask. Every entry also increments a nesting depth counter.

A return strobe runs the reverse path. The block reads the saved status word and both program counter halves back from the stack and restores them. It moves the stack pointer up by the bytes it consumed and decrements the nesting depth, which stops at zero.

After each entry the block sets a one-instruction guard. No new request is acknowledged until the processor reports that the first handler instruction has completed. This gives the handler a chance to lock out nesting before another request can be taken.

Top module: `irq_entry_seq`

## Requirements
- R1: A request is acknowledged only in an idle cycle with no guard set, a nonzero level, and a level not below the current mask, which is SR bits [14:12]. A request below the mask gets no acknowledge and starts no memory cycle.
- R2: The first three memory cycles after an acknowledge are 16-bit writes at byte addresses SP-2, SP-4 and SP-6, in that order. They carry PC[31:16], PC[15:0] and SR.
- R3: The stack writes are followed by two reads from the vector table. The first reads 24'hFFFF00 plus the vector and gives the low handler half. The second reads that address plus 2 and gives the high half. The new PC is {high, low}.
- R4: At the end of an entry, ctx_load is high for exactly one cycle, with pc_out equal to the handler address and sp_out equal to SP-6. sr_out is the captured SR with its mask field set to the accepted level plus one, or to 7 when the level is 7.
- R5: The 16-bit nesting depth resets to 0 and rises by one with every completed entry.
- R6: A return reads SP, then SP+2, then SP+4, as SR, PC[15:0] and PC[31:16]. It then pulses ctx_load with those values and with sp_out equal to SP+6, and lowers the nesting depth by one, holding it at 0 when it is already 0.
- R7: After an entry, no request is acknowledged until instr_done has been high for a cycle. An acceptable request is acknowledged in the cycle after that pulse.
- R8: While mem_ready is low, the pending memory cycle keeps its request, direction, address and write data unchanged. The sequence advances only on cycles where mem_ready is high.
- R9: With mem_ready always high, ctx_load rises six cycles after the acknowledge cycle.
- R10: When reti_req and an acceptable request arrive in the same idle cycle, the return is carried out and the request is not acknowledged in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_valid | input | 1 | Controller offers a request |
| irq_vector | input | 8 | Byte offset of the handler slot in the vector table |
| irq_level | input | 3 | Priority level of the offered request |
| irq_ack | output | 1 | Request taken this cycle |
| reti_req | input | 1 | Return-from-interrupt strobe |
| instr_done | input | 1 | One instruction has completed |
| pc_in | input | 32 | Current program counter |
| sr_in | input | 16 | Current status register |
| sp_in | input | 24 | Current stack pointer |
| ctx_load | output | 1 | Load pc_out, sr_out and sp_out into the processor |
| pc_out | output | 32 | Program counter to load |
| sr_out | output | 16 | Status register to load |
| sp_out | output | 24 | Stack pointer to load |
| nest_depth | output | 16 | Current interrupt nesting depth |
| mem_req | output | 1 | Memory cycle requested |
| mem_we | output | 1 | Memory cycle is a write |
| mem_addr | output | 24 | Byte address of the 16-bit word |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid when mem_ready is high |
| mem_ready | input | 1 | Memory cycle completes this cycle |

## Verification
On every cycle the assertions check the following:
- an acknowledge is followed by a write just below the captured stack pointer;
- a stalled memory cycle holds steady;
- ctx_load is a single-cycle pulse;
- an entry load raises the mask above zero and to at least the accepted level, and comes with no acknowledge;
- the depth counter steps by exactly one and stops at zero.

Only the bench scenarios can show the following:
- the complete order and contents of the stack and vector-table transactions;
- that popped values round-trip through nested entries;
- that a masked request and a request held back by the guard both stay unacknowledged;
- that a return wins over a simultaneous request;
- the six-cycle zero-wait latency.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

   typedef enum logic [3:0] {
      S_IDLE,
      S_PUSH_HI,
      S_PUSH_LO,
      S_PUSH_SR,
      S_VEC_LO,
      S_VEC_HI,
      S_POP_SR,
      S_POP_LO,
      S_POP_HI
   } seq_state_t;

   typedef enum logic {
      K_ENTRY,
      K_RETURN
   } ctx_kind_t;

endpackage

// File: rtl/irq_nest_ctr.sv
module irq_nest_ctr #(
   parameter int W       = 16,
   parameter bit SAT_INC = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   input  logic         dec,
   output logic [W-1:0] depth
);

   localparam logic [W-1:0] ONE = W'(1);

   logic [W-1:0] up_val;

   generate
      if (W < 2) begin : g_bad_width
         $error("irq_nest_ctr: W must be at least 2");
      end
      if (SAT_INC) begin : g_sat_up
         assign up_val = (depth == '1) ? depth : depth + ONE;
      end else begin : g_wrap_up
         assign up_val = depth + ONE;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         depth <= '0;
      end else if (inc && !dec) begin
         depth <= up_val;
      end else if (dec && !inc) begin
         if (depth != '0) depth <= depth - ONE;
      end
   end

   // R5: a lone increment below the top advances by exactly one
   a_r5_nest_step: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !dec && depth != '1) |=> depth == $past(depth) + ONE);

   // R6: a decrement at zero leaves zero
   a_r6_nest_floor: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !inc && depth == '0) |=> depth == '0);

endmodule

// File: rtl/irq_mask_next.sv
module irq_mask_next #(
   parameter int LVL_W = 3
) (
   input  logic [LVL_W-1:0] lvl,
   output logic [LVL_W-1:0] mask
);

   localparam logic [LVL_W-1:0] ONE = LVL_W'(1);

   generate
      if (LVL_W < 1) begin : g_bad_lvl
         $error("irq_mask_next: LVL_W must be positive");
      end
   endgenerate

   always_comb begin
      if (lvl == '1) mask = lvl;
      else           mask = lvl + ONE;
   end

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
   import irq_seq_pkg::*;
#(
   parameter int                ADDR_W   = 24,
   parameter int                DATA_W   = 16,
   parameter int                PC_W     = 32,
   parameter int                SR_W     = 16,
   parameter int                VEC_W    = 8,
   parameter int                LVL_W    = 3,
   parameter int                NEST_W   = 16,
   parameter int                MASK_LSB = 12,
   parameter logic [ADDR_W-1:0] VEC_BASE = 24'hFFFF00,
   parameter bit                NEST_SAT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              irq_valid,
   input  logic [VEC_W-1:0]  irq_vector,
   input  logic [LVL_W-1:0]  irq_level,
   output logic              irq_ack,
   input  logic              reti_req,
   input  logic              instr_done,
   input  logic [PC_W-1:0]   pc_in,
   input  logic [SR_W-1:0]   sr_in,
   input  logic [ADDR_W-1:0] sp_in,
   output logic              ctx_load,
   output logic [PC_W-1:0]   pc_out,
   output logic [SR_W-1:0]   sr_out,
   output logic [ADDR_W-1:0] sp_out,
   output logic [NEST_W-1:0] nest_depth,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_ready
);

   localparam int WB = DATA_W / 8;
   localparam logic [ADDR_W-1:0] STEP1 = ADDR_W'(WB);
   localparam logic [ADDR_W-1:0] STEP2 = ADDR_W'(2 * WB);
   localparam logic [ADDR_W-1:0] STEP3 = ADDR_W'(3 * WB);

   generate
      if (PC_W != 2 * DATA_W) begin : g_bad_pc
         $error("irq_entry_seq: PC_W must be two bus words");
      end
      if (SR_W != DATA_W) begin : g_bad_sr
         $error("irq_entry_seq: SR_W must equal DATA_W");
      end
      if (VEC_W > ADDR_W) begin : g_bad_vec
         $error("irq_entry_seq: VEC_W exceeds ADDR_W");
      end
      if (MASK_LSB + LVL_W > SR_W) begin : g_bad_mask
         $error("irq_entry_seq: mask field outside SR");
      end
      if ((DATA_W % 8) != 0) begin : g_bad_data
         $error("irq_entry_seq: DATA_W must be whole bytes");
      end
   endgenerate

   seq_state_t          state;
   ctx_kind_t           kind_q;
   logic [PC_W-1:0]     pc_q;
   logic [SR_W-1:0]     sr_q;
   logic [ADDR_W-1:0]   sp_q;
   logic [VEC_W-1:0]    vec_q;
   logic [LVL_W-1:0]    lvl_q;
   logic [DATA_W-1:0]   lo_q;
   logic [SR_W-1:0]     sr_pop_q;
   logic                inhib_q;
   logic [LVL_W-1:0]    mask_nx;
   logic [LVL_W-1:0]    cur_mask;
   logic [SR_W-1:0]     sr_entry;
   logic [ADDR_W-1:0]   vec_addr;
   logic                take;
   logic                nest_inc;
   logic                nest_dec;

   assign cur_mask = sr_in[MASK_LSB +: LVL_W];
   assign take     = (state == S_IDLE) && irq_valid && !inhib_q && !reti_req
                     && (irq_level != '0) && (irq_level >= cur_mask);
   assign irq_ack  = take;
   assign vec_addr = VEC_BASE + ADDR_W'(vec_q);
   assign nest_inc = (state == S_VEC_HI) && mem_ready;
   assign nest_dec = (state == S_POP_HI) && mem_ready;

   irq_mask_next #(.LVL_W(LVL_W)) u_mask (
      .lvl  (lvl_q),
      .mask (mask_nx)
   );

   irq_nest_ctr #(.W(NEST_W), .SAT_INC(NEST_SAT)) u_nest (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (nest_inc),
      .dec   (nest_dec),
      .depth (nest_depth)
   );

   always_comb begin
      sr_entry = sr_q;
      sr_entry[MASK_LSB +: LVL_W] = mask_nx;
   end

   always_comb begin
      mem_req   = 1'b1;
      mem_we    = 1'b0;
      mem_addr  = sp_q;
      mem_wdata = '0;
      case (state)
         S_PUSH_HI: begin
            mem_we    = 1'b1;
            mem_addr  = sp_q - STEP1;
            mem_wdata = pc_q[PC_W-1 -: DATA_W];
         end
         S_PUSH_LO: begin
            mem_we    = 1'b1;
            mem_addr  = sp_q - STEP2;
            mem_wdata = pc_q[DATA_W-1:0];
         end
         S_PUSH_SR: begin
            mem_we    = 1'b1;
            mem_addr  = sp_q - STEP3;
            mem_wdata = sr_q;
         end
         S_VEC_LO: mem_addr = vec_addr;
         S_VEC_HI: mem_addr = vec_addr + STEP1;
         S_POP_SR: mem_addr = sp_q;
         S_POP_LO: mem_addr = sp_q + STEP1;
         S_POP_HI: mem_addr = sp_q + STEP2;
         default:  mem_req  = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= S_IDLE;
         kind_q   <= K_ENTRY;
         pc_q     <= '0;
         sr_q     <= '0;
         sp_q     <= '0;
         vec_q    <= '0;
         lvl_q    <= '0;
         lo_q     <= '0;
         sr_pop_q <= '0;
         inhib_q  <= 1'b0;
         ctx_load <= 1'b0;
         pc_out   <= '0;
         sr_out   <= '0;
         sp_out   <= '0;
      end else begin
         ctx_load <= 1'b0;
         if (instr_done) inhib_q <= 1'b0;
         case (state)
            S_IDLE: begin
               if (reti_req) begin
                  sp_q   <= sp_in;
                  kind_q <= K_RETURN;
                  state  <= S_POP_SR;
               end else if (take) begin
                  pc_q   <= pc_in;
                  sr_q   <= sr_in;
                  sp_q   <= sp_in;
                  vec_q  <= irq_vector;
                  lvl_q  <= irq_level;
                  kind_q <= K_ENTRY;
                  state  <= S_PUSH_HI;
               end
            end
            S_PUSH_HI: if (mem_ready) state <= S_PUSH_LO;
            S_PUSH_LO: if (mem_ready) state <= S_PUSH_SR;
            S_PUSH_SR: if (mem_ready) state <= S_VEC_LO;
            S_VEC_LO: if (mem_ready) begin
               lo_q  <= mem_rdata;
               state <= S_VEC_HI;
            end
            S_VEC_HI: if (mem_ready) begin
               pc_out   <= {mem_rdata, lo_q};
               sr_out   <= sr_entry;
               sp_out   <= sp_q - STEP3;
               ctx_load <= 1'b1;
               inhib_q  <= 1'b1;
               state    <= S_IDLE;
            end
            S_POP_SR: if (mem_ready) begin
               sr_pop_q <= mem_rdata;
               state    <= S_POP_LO;
            end
            S_POP_LO: if (mem_ready) begin
               lo_q  <= mem_rdata;
               state <= S_POP_HI;
            end
            S_POP_HI: if (mem_ready) begin
               pc_out   <= {mem_rdata, lo_q};
               sr_out   <= sr_pop_q;
               sp_out   <= sp_q + STEP3;
               ctx_load <= 1'b1;
               state    <= S_IDLE;
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   // R2: an acknowledge is followed by the first push just below the captured SP
   a_r2_push_follows_ack: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack |=> (mem_req && mem_we && mem_addr == $past(sp_in) - STEP1));

   // R8: a stalled memory cycle holds steady
   a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we)
                                   && $stable(mem_addr) && $stable(mem_wdata)));

   // R4: the context load is a single-cycle pulse
   a_r4_load_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      ctx_load |=> !ctx_load);

   // R4: an entry load raises the mask to at least the accepted level
   a_r4_mask_raised: assert property (@(posedge clk) disable iff (!rst_n)
      (ctx_load && kind_q == K_ENTRY) |->
         (sr_out[MASK_LSB +: LVL_W] >= lvl_q && sr_out[MASK_LSB +: LVL_W] != '0));

   // R7: no acknowledge in the cycle an entry completes
   a_r7_guard_after_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (ctx_load && kind_q == K_ENTRY) |-> !irq_ack);

endmodule

// File: tb/irq_entry_seq_test.sv
module irq_entry_seq_test;

   localparam logic [23:0] VBASE = 24'hFFFF00;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        irq_valid = 1'b0;
   logic [7:0]  irq_vector = '0;
   logic [2:0]  irq_level = '0;
   logic        irq_ack;
   logic        reti_req = 1'b0;
   logic        instr_done = 1'b0;
   logic [31:0] cpu_pc;
   logic [15:0] cpu_sr;
   logic [23:0] cpu_sp;
   logic        ctx_load;
   logic [31:0] pc_out;
   logic [15:0] sr_out;
   logic [23:0] sp_out;
   logic [15:0] nest_depth;
   logic        mem_req;
   logic        mem_we;
   logic [23:0] mem_addr;
   logic [15:0] mem_wdata;
   logic [15:0] mem_rdata = '0;
   logic        mem_ready = 1'b1;

   always #2 clk = ~clk;

   irq_entry_seq uut (
      .clk(clk), .rst_n(rst_n),
      .irq_valid(irq_valid), .irq_vector(irq_vector), .irq_level(irq_level),
      .irq_ack(irq_ack), .reti_req(reti_req), .instr_done(instr_done),
      .pc_in(cpu_pc), .sr_in(cpu_sr), .sp_in(cpu_sp),
      .ctx_load(ctx_load), .pc_out(pc_out), .sr_out(sr_out), .sp_out(sp_out),
      .nest_depth(nest_depth),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
   );

   typedef struct {
      bit          we;
      logic [23:0] addr;
      logic [15:0] data;
      string       tag;
   } txn_t;

   typedef struct {
      logic [31:0] pc;
      logic [15:0] sr;
   } ctx_t;

   txn_t        expq[$];
   ctx_t        saved[$];
   logic [15:0] mem [int];
   int          n_checks = 0;
   int          n_fail = 0;
   int          exp_nest = 0;
   int          cyc = 0;
   bit          slow = 1'b0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   function automatic logic [15:0] rd(input logic [23:0] a);
      if (mem.exists(int'(a))) return mem[int'(a)];
      return 16'h0000;
   endfunction

   function automatic logic [15:0] with_mask(input logic [15:0] s, input logic [2:0] m);
      logic [15:0] r;
      r = s;
      r[14:12] = m;
      return r;
   endfunction

   // memory model and transaction reference, evaluated away from the active edge
   always @(negedge clk) begin
      bit rdy;
      cyc++;
      rdy = slow ? ((cyc % 3) == 0) : 1'b1;
      mem_ready = rdy;
      mem_rdata = mem_req ? rd(mem_addr) : 16'h0000;
      if (rst_n && mem_req && rdy) begin
         if (expq.size() == 0) begin
            chk(1'b0, "R2", "unexpected memory cycle", {40'h0, mem_addr}, 64'h0);
         end else begin
            txn_t t;
            t = expq.pop_front();
            chk(mem_we == t.we && mem_addr == t.addr && (!t.we || mem_wdata == t.data),
                t.tag, "memory cycle {we,addr,wdata}",
                {23'h0, mem_we, mem_addr, mem_wdata},
                {23'h0, t.we, t.addr, t.data});
         end
         if (mem_we) mem[int'(mem_addr)] = mem_wdata;
      end
   end

   task automatic wait_load(input string tag, output int lat);
      lat = 0;
      while (!ctx_load && lat < 200) begin
         @(negedge clk); #1;
         lat++;
      end
      chk(ctx_load, tag, "ctx_load seen", {63'h0, ctx_load}, 64'h1);
   endtask

   task automatic step_instr();
      @(negedge clk);
      instr_done = 1'b1;
      @(negedge clk);
      instr_done = 1'b0;
   endtask

   task automatic do_entry(input logic [7:0] vec, input logic [2:0] lvl,
                           input bit slow_mem, input bit guard_test);
      logic [2:0]  m;
      logic [15:0] lo, hi;
      logic [31:0] exp_pc;
      logic [15:0] exp_sr;
      logic [23:0] exp_sp;
      int          n;
      int          lat;
      txn_t        t;
      t.tag = "R2"; t.we = 1'b1;
      t.addr = cpu_sp - 24'd2; t.data = cpu_pc[31:16]; expq.push_back(t);
      t.addr = cpu_sp - 24'd4; t.data = cpu_pc[15:0];  expq.push_back(t);
      t.addr = cpu_sp - 24'd6; t.data = cpu_sr;        expq.push_back(t);
      t.tag = "R3"; t.we = 1'b0; t.data = '0;
      t.addr = VBASE + {16'h0, vec};          expq.push_back(t);
      t.addr = VBASE + {16'h0, vec} + 24'd2;  expq.push_back(t);
      lo = rd(VBASE + {16'h0, vec});
      hi = rd(VBASE + {16'h0, vec} + 24'd2);
      exp_pc = {hi, lo};
      m = (lvl == 3'd7) ? 3'd7 : lvl + 3'd1;
      exp_sr = with_mask(cpu_sr, m);
      exp_sp = cpu_sp - 24'd6;
      saved.push_front('{pc: cpu_pc, sr: cpu_sr});
      slow = slow_mem;
      @(negedge clk);
      irq_valid = 1'b1; irq_vector = vec; irq_level = lvl;
      #1;
      if (guard_test) begin
         for (int i = 0; i < 5; i++) begin
            chk(!irq_ack && !mem_req, "R7", "no ack while guard set",
                {62'h0, irq_ack, mem_req}, 64'h0);
            @(negedge clk); #1;
         end
         instr_done = 1'b1;
         #1;
         chk(!irq_ack, "R7", "no ack in instr_done cycle", {63'h0, irq_ack}, 64'h0);
         @(negedge clk);
         instr_done = 1'b0;
         #1;
         chk(irq_ack, "R7", "ack after instr_done", {63'h0, irq_ack}, 64'h1);
      end
      n = 0;
      while (!irq_ack && n < 50) begin
         @(negedge clk); #1;
         n++;
      end
      chk(irq_ack, "R1", "request acknowledged", {63'h0, irq_ack}, 64'h1);
      @(negedge clk);
      irq_valid = 1'b0;
      #1;
      wait_load("R4", lat);
      lat = lat + 1;
      if (!slow_mem)
         chk(lat == 6, "R9", "zero-wait entry latency", 64'(lat), 64'd6);
      chk(pc_out == exp_pc, "R3", "handler pc", {32'h0, pc_out}, {32'h0, exp_pc});
      chk(sr_out == exp_sr, "R4", "entry sr with mask", {48'h0, sr_out}, {48'h0, exp_sr});
      chk(sp_out == exp_sp, "R4", "entry sp", {40'h0, sp_out}, {40'h0, exp_sp});
      exp_nest = (exp_nest == 65535) ? exp_nest : exp_nest + 1;
      chk(nest_depth == 16'(exp_nest), "R5", "depth after entry",
          {48'h0, nest_depth}, 64'(exp_nest));
      cpu_pc = pc_out; cpu_sr = sr_out; cpu_sp = sp_out;
      @(negedge clk); #1;
      chk(!ctx_load, "R4", "ctx_load single pulse", {63'h0, ctx_load}, 64'h0);
      slow = 1'b0;
   endtask

   task automatic do_reti(input bit clash, input bit slow_mem);
      logic [31:0] exp_pc;
      logic [15:0] exp_sr;
      logic [23:0] exp_sp;
      int          lat;
      txn_t        t;
      t.tag = "R6"; t.we = 1'b0; t.data = '0;
      t.addr = cpu_sp;          expq.push_back(t);
      t.addr = cpu_sp + 24'd2;  expq.push_back(t);
      t.addr = cpu_sp + 24'd4;  expq.push_back(t);
      if (saved.size() != 0) begin
         ctx_t c;
         c = saved.pop_front();
         exp_pc = c.pc; exp_sr = c.sr;
      end else begin
         exp_pc = {rd(cpu_sp + 24'd4), rd(cpu_sp + 24'd2)};
         exp_sr = rd(cpu_sp);
      end
      exp_sp = cpu_sp + 24'd6;
      exp_nest = (exp_nest == 0) ? 0 : exp_nest - 1;
      slow = slow_mem;
      @(negedge clk);
      reti_req = 1'b1;
      if (clash) begin
         irq_valid = 1'b1; irq_vector = 8'h40; irq_level = 3'd7;
      end
      #1;
      if (clash)
         chk(!irq_ack, "R10", "return wins over request", {63'h0, irq_ack}, 64'h0);
      @(negedge clk);
      reti_req = 1'b0;
      irq_valid = 1'b0;
      #1;
      wait_load("R6", lat);
      chk(pc_out == exp_pc, "R6", "restored pc", {32'h0, pc_out}, {32'h0, exp_pc});
      chk(sr_out == exp_sr, "R6", "restored sr", {48'h0, sr_out}, {48'h0, exp_sr});
      chk(sp_out == exp_sp, "R6", "return sp", {40'h0, sp_out}, {40'h0, exp_sp});
      chk(nest_depth == 16'(exp_nest), "R6", "depth after return",
          {48'h0, nest_depth}, 64'(exp_nest));
      cpu_pc = pc_out; cpu_sr = sr_out; cpu_sp = sp_out;
      @(negedge clk);
      slow = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      chk(1'b0, "R1", "watchdog expired", 64'h0, 64'h1);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      cpu_pc = 32'h1234_5678;
      cpu_sr = 16'h0005;
      cpu_sp = 24'h001000;
      for (int v = 0; v < 256; v += 4) begin
         mem[int'(VBASE + 24'(v))]      = 16'h4000 + 16'(v);
         mem[int'(VBASE + 24'(v) + 2)]  = 16'(v);
      end

      repeat (3) @(negedge clk);
      #1;
      chk(nest_depth == 16'h0, "R5", "reset depth", {48'h0, nest_depth}, 64'h0);
      chk(!mem_req && !ctx_load && !irq_ack, "R1", "reset outputs idle",
          {61'h0, mem_req, ctx_load, irq_ack}, 64'h0);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // level 3 against mask 0, zero-wait memory
      do_entry(8'h10, 3'd3, 1'b0, 1'b0);
      // level 6 held back by the guard, then taken with wait states
      do_entry(8'h20, 3'd6, 1'b1, 1'b1);

      // level 5 against mask 7: ignored
      step_instr();
      @(negedge clk);
      irq_valid = 1'b1; irq_vector = 8'h28; irq_level = 3'd5;
      for (int i = 0; i < 6; i++) begin
         #1;
         chk(!irq_ack && !mem_req, "R1", "masked request ignored",
             {62'h0, irq_ack, mem_req}, 64'h0);
         @(negedge clk);
      end
      irq_valid = 1'b0;
      #1;
      chk(nest_depth == 16'(exp_nest) && !ctx_load, "R1", "masked request left state",
          {47'h0, ctx_load, nest_depth}, 64'(exp_nest));

      // level 7: mask stays 7
      do_entry(8'h30, 3'd7, 1'b0, 1'b0);

      step_instr();
      do_reti(1'b1, 1'b0);
      do_reti(1'b0, 1'b1);
      do_reti(1'b0, 1'b0);
      // return with depth already zero
      do_reti(1'b0, 1'b0);

      repeat (3) @(negedge clk);
      chk(expq.size() == 0, "R8", "all memory cycles seen", 64'(expq.size()), 64'h0);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule